// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Dispatcher

This block collects up to 64 level-sensitive peripheral interrupt sources and serves them to two CPUs. The raw source levels are shared, and each CPU owns its own bank of enable bits. A source is pending for a CPU when its level is high and that CPU's enable bit is set. Each CPU gets one interrupt line that is high while anything is pending for it.

When a CPU strobes its service request, a per-CPU selector chooses one pending source. It gives no source a fixed priority. The search starts at the index just after the one that CPU was last given, and it wraps around the source count. The enable banks can be written and read as 32-bit words. Two single-source commands also change them: one disables a source everywhere, and one enables it on the CPUs named in an affinity vector. An optional cascade window marks a contiguous run of source indices as external inputs. A grant that falls in that window is reported with the external number instead of the source index.

Each selector is a two-state machine. In `SEL_IDLE` no grant is shown. The transition *accept* moves it to `SEL_GRANT` when a request meets a non-empty pending vector. `SEL_GRANT` drives the grant for exactly one cycle. After that, the transition *release* returns it to `SEL_IDLE`, or *re-accept* keeps it in `SEL_GRANT` when a new request meets pending work. The transition *miss* holds `SEL_IDLE` when a request finds nothing pending.

Top module: `irq_rr_dispatch`

## Requirements
- R1: For each CPU, the pending vector is the status input ANDed bit by bit with that CPU's enable bank.
- R2: `irq_o[c]` is high in the same cycle that CPU c's pending vector has any bit set, and low otherwise.
- R3: If `svc_req_i[c]` is high at a clock edge and CPU c has pending work, `gnt_valid_o[c]` is high for the following cycle. The granted source is the first pending index found by scanning upward from CPU c's pointer, wrapping modulo NUM_SRC. The pointer then becomes that index plus one, modulo NUM_SRC.
- R4: If a request finds nothing pending, no grant appears in the following cycle and the pointer is unchanged.
- R5: Each CPU has its own pointer and its own grant outputs. A grant to one CPU leaves the other CPU's pointer alone.
- R6: A disable command (`mask_cmd_i`) clears the enable bit of `cmd_src_i` in every CPU's bank. An enable command (`unmask_cmd_i`) sets that bit for every CPU whose `cmd_aff_i` bit is 1, and clears it for every CPU whose bit is 0. If both commands arrive together, the disable wins. A command overrides a bus write to the same bit in the same cycle.
- R7: The bus address has three fields. Bit 0 is the register word, bit 1 is the kind (0 = enable bank, 1 = status), and bit 2 is the CPU. Register word r holds logical word r XOR (NUM_SRC/32 − 1). With 64 sources, register word 0 therefore carries sources 63..32 and register word 1 carries sources 31..0.
- R8: When `ext_en_i` is 1 and the granted index i satisfies `ext_start_i` ≤ i ≤ `ext_end_i`, `gnt_ext_o[c]` is 1 and the reported index is i − `ext_start_i`. Otherwise `gnt_ext_o[c]` is 0 and the reported index is i.
- R9: A bus write to an enable word takes effect at the next clock edge and is visible in the following cycle. A bus write to a status word is ignored. A read returns the addressed word combinationally.
- R10: After reset, every enable bit is 0, no grant is shown, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | NUM_SRC | Raw source levels, sampled every cycle |
| bus_addr_i | input | ADDR_W (3) | Word address: {cpu, kind, word} |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| mask_cmd_i | input | 1 | Disable `cmd_src_i` on all CPUs |
| unmask_cmd_i | input | 1 | Enable `cmd_src_i` according to `cmd_aff_i` |
| cmd_src_i | input | SRC_W (6) | Source index for a command |
| cmd_aff_i | input | NUM_CPU | Affinity vector for enable commands |
| ext_en_i | input | 1 | Cascade window enable |
| ext_start_i | input | SRC_W | First index of the cascade window |
| ext_end_i | input | SRC_W | Last index of the cascade window |
| svc_req_i | input | NUM_CPU | Service-request strobe per CPU |
| irq_o | output | NUM_CPU | Interrupt line per CPU |
| gnt_valid_o | output | NUM_CPU | One-cycle grant pulse per CPU |
| gnt_idx_o | output | NUM_CPU*SRC_W | Granted index per CPU; CPU c occupies bits [c*SRC_W +: SRC_W] |
| gnt_ext_o | output | NUM_CPU | Grant lies in the cascade window |

## Verification
The assertions check every cycle that the selector behaves correctly around requests:
- A request that meets pending work is followed by a grant.
- A request that meets nothing produces no grant and leaves the pointer still.
- A grant never appears without a request.
- A cascaded grant's number stays inside the window's span.
- A disable or enable command leaves each bank bit as the command and affinity dictate.

Only the bench's scenarios can show the following:
- The fairness of the scan order across many requests.
- The word reversal on reads and writes.
- The independence of the two pointers.
- The exact reported numbers, which the bench compares against its behavioural model on every clock.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;

    localparam int unsigned BUS_W = 32;

    typedef enum logic [0:0] {
        SEL_IDLE  = 1'b0,
        SEL_GRANT = 1'b1
    } sel_state_e;

    typedef enum logic [0:0] {
        KIND_MASK   = 1'b0,
        KIND_STATUS = 1'b1
    } reg_kind_e;

endpackage

// File: rtl/irq_rr_mask_bank.sv
module irq_rr_mask_bank
    import irq_rr_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned NUM_CPU = 2,
    localparam int unsigned SRC_W     = $clog2(NUM_SRC),
    localparam int unsigned NUM_WORDS = NUM_SRC / BUS_W,
    localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [CPU_W-1:0]           wr_cpu_i,
    input  logic [WORD_W-1:0]          wr_word_i,
    input  logic [BUS_W-1:0]           wr_data_i,
    input  logic                       mask_cmd_i,
    input  logic                       unmask_cmd_i,
    input  logic [SRC_W-1:0]           cmd_src_i,
    input  logic [NUM_CPU-1:0]         cmd_aff_i,
    output logic [NUM_CPU*NUM_SRC-1:0] mask_o
);

    // register word r carries logical word r ^ (NUM_WORDS-1)
    logic [WORD_W-1:0] log_word;
    logic              word_ok;

    always_comb begin
        log_word = wr_word_i ^ WORD_W'(NUM_WORDS - 1);
        word_ok  = (int'(wr_word_i) < int'(NUM_WORDS));
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_SRC-1:0] bank_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q <= '0;
            end else begin
                if (wr_en_i && word_ok && (wr_cpu_i == CPU_W'(c))) begin
                    bank_q[int'(log_word)*BUS_W +: BUS_W] <= wr_data_i;
                end
                // commands are applied last so they win over a bus write
                if (mask_cmd_i) begin
                    bank_q[cmd_src_i] <= 1'b0;
                end else if (unmask_cmd_i) begin
                    bank_q[cmd_src_i] <= cmd_aff_i[c];
                end
            end
        end

        assign mask_o[c*NUM_SRC +: NUM_SRC] = bank_q;

        AST_MASK_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            mask_cmd_i |=> !bank_q[$past(cmd_src_i)]); // R6

        AST_UNMASK_FOLLOWS_AFF: assert property (@(posedge clk) disable iff (!rst_n)
            (unmask_cmd_i && !mask_cmd_i) |=> (bank_q[$past(cmd_src_i)] == $past(cmd_aff_i[c]))); // R6
    end

endmodule

// File: rtl/irq_rr_selector.sv
module irq_rr_selector
    import irq_rr_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    localparam int unsigned SRC_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pending_i,
    input  logic               svc_req_i,
    input  logic               ext_en_i,
    input  logic [SRC_W-1:0]   ext_start_i,
    input  logic [SRC_W-1:0]   ext_end_i,
    output logic               gnt_valid_o,
    output logic [SRC_W-1:0]   gnt_idx_o,
    output logic               gnt_ext_o
);

    sel_state_e       state_q, state_d;
    logic [SRC_W-1:0] ptr_q;
    logic [SRC_W-1:0] idx_q;
    logic             ext_q;

    logic             hit;
    logic [SRC_W-1:0] hit_idx;
    logic             in_window;
    logic [SRC_W-1:0] report_idx;
    logic             accept;

    // upward scan from the pointer; index arithmetic wraps in SRC_W bits
    always_comb begin
        logic [SRC_W-1:0] cand;
        hit     = 1'b0;
        hit_idx = ptr_q;
        for (int k = 0; k < int'(NUM_SRC); k++) begin
            cand = ptr_q + SRC_W'(k);
            if (!hit && pending_i[cand]) begin
                hit     = 1'b1;
                hit_idx = cand;
            end
        end
    end

    always_comb begin
        in_window  = ext_en_i && (hit_idx >= ext_start_i) && (hit_idx <= ext_end_i);
        report_idx = in_window ? (hit_idx - ext_start_i) : hit_idx;
        accept     = svc_req_i && hit;
    end

    // next-state logic: accept / re-accept / release / miss
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_IDLE:  state_d = accept ? SEL_GRANT : SEL_IDLE;
            SEL_GRANT: state_d = accept ? SEL_GRANT : SEL_IDLE;
            default:   state_d = SEL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            idx_q <= '0;
            ext_q <= 1'b0;
        end else if (accept) begin
            ptr_q <= hit_idx + SRC_W'(1);
            idx_q <= report_idx;
            ext_q <= in_window;
        end
    end

    always_comb begin
        gnt_idx_o = idx_q;
        gnt_ext_o = ext_q;
        unique case (state_q)
            SEL_IDLE:  gnt_valid_o = 1'b0;
            SEL_GRANT: gnt_valid_o = 1'b1;
            default:   gnt_valid_o = 1'b0;
        endcase
    end

    AST_GNT_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req_i && (|pending_i)) |=> gnt_valid_o); // R3

    AST_NO_GNT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req_i && !(|pending_i)) |=> (!gnt_valid_o && $stable(ptr_q))); // R4

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> $past(svc_req_i)); // R3

    AST_EXT_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && gnt_ext_o) |-> (gnt_idx_o <= $past(ext_end_i - ext_start_i))); // R8

endmodule

// File: rtl/irq_rr_read_mux.sv
module irq_rr_read_mux
    import irq_rr_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned NUM_CPU = 2,
    localparam int unsigned NUM_WORDS = NUM_SRC / BUS_W,
    localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned ADDR_W    = CPU_W + 1 + WORD_W
) (
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [NUM_SRC-1:0]         status_i,
    input  logic [NUM_CPU*NUM_SRC-1:0] mask_i,
    output logic [BUS_W-1:0]           rdata_o
);

    logic [WORD_W-1:0] reg_word;
    logic [WORD_W-1:0] log_word;
    reg_kind_e         kind;
    logic [CPU_W-1:0]  cpu;

    always_comb begin
        reg_word = addr_i[WORD_W-1:0];
        log_word = reg_word ^ WORD_W'(NUM_WORDS - 1);
        kind     = reg_kind_e'(addr_i[WORD_W]);
        cpu      = addr_i[ADDR_W-1:WORD_W+1];
    end

    always_comb begin
        rdata_o = '0;
        for (int w = 0; w < int'(NUM_WORDS); w++) begin
            if (int'(log_word) == w && int'(reg_word) < int'(NUM_WORDS)) begin
                if (kind == KIND_STATUS) begin
                    rdata_o = status_i[w*BUS_W +: BUS_W];
                end else begin
                    for (int c = 0; c < int'(NUM_CPU); c++) begin
                        if (int'(cpu) == c) begin
                            rdata_o = mask_i[c*NUM_SRC + w*BUS_W +: BUS_W];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_rr_dispatch.sv
module irq_rr_dispatch
    import irq_rr_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned NUM_CPU = 2,
    localparam int unsigned SRC_W     = $clog2(NUM_SRC),
    localparam int unsigned NUM_WORDS = NUM_SRC / BUS_W,
    localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned ADDR_W    = CPU_W + 1 + WORD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       status_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic                     bus_we_i,
    input  logic [BUS_W-1:0]         bus_wdata_i,
    output logic [BUS_W-1:0]         bus_rdata_o,
    input  logic                     mask_cmd_i,
    input  logic                     unmask_cmd_i,
    input  logic [SRC_W-1:0]         cmd_src_i,
    input  logic [NUM_CPU-1:0]       cmd_aff_i,
    input  logic                     ext_en_i,
    input  logic [SRC_W-1:0]         ext_start_i,
    input  logic [SRC_W-1:0]         ext_end_i,
    input  logic [NUM_CPU-1:0]       svc_req_i,
    output logic [NUM_CPU-1:0]       irq_o,
    output logic [NUM_CPU-1:0]       gnt_valid_o,
    output logic [NUM_CPU*SRC_W-1:0] gnt_idx_o,
    output logic [NUM_CPU-1:0]       gnt_ext_o
);

    logic [NUM_CPU*NUM_SRC-1:0] mask_flat;
    logic                       wr_mask;
    logic [CPU_W-1:0]           wr_cpu;

    always_comb begin
        wr_cpu  = bus_addr_i[ADDR_W-1:WORD_W+1];
        wr_mask = bus_we_i
               && (reg_kind_e'(bus_addr_i[WORD_W]) == KIND_MASK)
               && (int'(wr_cpu) < int'(NUM_CPU));
    end

    irq_rr_mask_bank #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_mask),
        .wr_cpu_i     (wr_cpu),
        .wr_word_i    (bus_addr_i[WORD_W-1:0]),
        .wr_data_i    (bus_wdata_i),
        .mask_cmd_i   (mask_cmd_i),
        .unmask_cmd_i (unmask_cmd_i),
        .cmd_src_i    (cmd_src_i),
        .cmd_aff_i    (cmd_aff_i),
        .mask_o       (mask_flat)
    );

    irq_rr_read_mux #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU)
    ) u_rmux (
        .addr_i   (bus_addr_i),
        .status_i (status_i),
        .mask_i   (mask_flat),
        .rdata_o  (bus_rdata_o)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_sel
        logic [NUM_SRC-1:0] pending;

        assign pending  = status_i & mask_flat[c*NUM_SRC +: NUM_SRC];
        assign irq_o[c] = |pending;

        irq_rr_selector #(
            .NUM_SRC (NUM_SRC)
        ) u_sel (
            .clk         (clk),
            .rst_n       (rst_n),
            .pending_i   (pending),
            .svc_req_i   (svc_req_i[c]),
            .ext_en_i    (ext_en_i),
            .ext_start_i (ext_start_i),
            .ext_end_i   (ext_end_i),
            .gnt_valid_o (gnt_valid_o[c]),
            .gnt_idx_o   (gnt_idx_o[c*SRC_W +: SRC_W]),
            .gnt_ext_o   (gnt_ext_o[c])
        );
    end

endmodule

// File: tb/irq_rr_dispatch_tb_top.sv
`timescale 1ns/1ps
module irq_rr_dispatch_tb_top;

    localparam int N     = 64;
    localparam int NC    = 2;
    localparam int SW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  status = '0;
    logic [2:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          mcmd = 1'b0;
    logic          ucmd = 1'b0;
    logic [SW-1:0] csrc = '0;
    logic [NC-1:0] caff = '0;
    logic          xen = 1'b0;
    logic [SW-1:0] xs = '0;
    logic [SW-1:0] xe = '0;
    logic [NC-1:0] req = '0;
    logic [NC-1:0] irq;
    logic [NC-1:0] gv;
    logic [NC*SW-1:0] gidx;
    logic [NC-1:0] gext;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    logic [N-1:0] m_mask [NC];
    int           m_ptr  [NC];
    bit           m_gv   [NC];
    int           m_idx  [NC];
    bit           m_ext  [NC];

    always #10 clk = ~clk;

    irq_rr_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .status_i(status),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .mask_cmd_i(mcmd), .unmask_cmd_i(ucmd), .cmd_src_i(csrc), .cmd_aff_i(caff),
        .ext_en_i(xen), .ext_start_i(xs), .ext_end_i(xe),
        .svc_req_i(req), .irq_o(irq), .gnt_valid_o(gv), .gnt_idx_o(gidx), .gnt_ext_o(gext)
    );

    task automatic chk(input bit ok, input string req_tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req_tag, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                m_mask[c] = '0; m_ptr[c] = 0; m_gv[c] = 0; m_idx[c] = 0; m_ext[c] = 0;
            end
            return;
        end
        for (int c = 0; c < NC; c++) begin
            logic [N-1:0] pend;
            int found;
            pend  = status & m_mask[c];
            found = -1;
            m_gv[c] = 0;
            if (req[c]) begin
                for (int k = 0; k < N; k++) begin
                    int i;
                    i = (m_ptr[c] + k) % N;
                    if (found < 0 && pend[i]) found = i;
                end
                if (found >= 0) begin
                    m_gv[c] = 1;
                    if (xen && found >= int'(xs) && found <= int'(xe)) begin
                        m_ext[c] = 1; m_idx[c] = found - int'(xs);
                    end else begin
                        m_ext[c] = 0; m_idx[c] = found;
                    end
                    m_ptr[c] = (found + 1) % N;
                end
            end
        end
        if (we && addr[1] == 1'b0) begin
            int lw;
            lw = addr[0] ^ 1;
            m_mask[addr[2]][lw*32 +: 32] = wdata;
        end
        for (int c = 0; c < NC; c++) begin
            if (mcmd) m_mask[c][csrc] = 1'b0;
            else if (ucmd) m_mask[c][csrc] = caff[c];
        end
    endtask

    task automatic check_all();
        logic [31:0] exp_rd;
        int lw;
        for (int c = 0; c < NC; c++) begin
            bit exp_irq;
            exp_irq = |(status & m_mask[c]);
            chk(irq[c] == exp_irq, "R1 R2", $sformatf("irq[%0d]", c), irq[c], exp_irq);
            chk(gv[c] == m_gv[c], "R3 R4", $sformatf("gnt_valid[%0d]", c), gv[c], m_gv[c]);
            if (m_gv[c] && gv[c]) begin
                chk(int'(gidx[c*SW +: SW]) == m_idx[c], "R3 R5", $sformatf("gnt_idx[%0d]", c),
                    gidx[c*SW +: SW], m_idx[c]);
                chk(gext[c] == m_ext[c], "R8", $sformatf("gnt_ext[%0d]", c), gext[c], m_ext[c]);
            end
        end
        lw = addr[0] ^ 1;
        exp_rd = addr[1] ? status[lw*32 +: 32] : m_mask[addr[2]][lw*32 +: 32];
        chk(rdata == exp_rd, "R6 R7 R9", $sformatf("rdata@%0d", addr), rdata, exp_rd);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_inputs();
        we = 0; mcmd = 0; ucmd = 0; req = '0;
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_mask[c] = '0; m_ptr[c] = 0; m_gv[c] = 0; m_idx[c] = 0; m_ext[c] = 0;
        end
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        status = '1;
        #1;
        chk(irq == '0, "R10", "irq after reset", irq, 0);
        chk(gv == '0, "R10", "grant after reset", gv, 0);
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a);
            #1;
            if (a[1] == 0) chk(rdata == 32'h0, "R10", "mask after reset", rdata, 0);
        end
        addr = 3'd0;
        // R7 R9: word reversal on cpu0; sources 32, 0, 1, 31 enabled
        we = 1; addr = 3'b000; wdata = 32'h0000_0001; step();
        addr = 3'b001; wdata = 32'h8000_0003; step();
        we = 0; addr = 3'b000; step();
        // R3: round-robin service of cpu0
        for (int i = 0; i < 6; i++) begin req = 2'b01; step(); end
        req = '0; step();
        // R9: write to status word is ignored
        we = 1; addr = 3'b010; wdata = 32'hFFFF_FFFF; step();
        we = 0; addr = 3'b000; step();
        // R6: unmask source 5 for cpu1 only, then mask source 0 everywhere
        ucmd = 1; csrc = 6'd5; caff = 2'b10; step();
        ucmd = 0; addr = 3'b101; step();
        mcmd = 1; ucmd = 1; csrc = 6'd0; caff = 2'b11; step();
        mcmd = 0; ucmd = 0; addr = 3'b001; step();
        // R5: both cpus request
        for (int i = 0; i < 4; i++) begin req = 2'b11; step(); end
        // R4: request with nothing pending
        status = '0; req = 2'b11; step(); step();
        // R8: cascade window 30..33
        status = '1; xen = 1; xs = 6'd30; xe = 6'd33; req = 2'b01;
        for (int i = 0; i < 5; i++) step();
        idle_inputs(); step();
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            status = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            req    = NC'($urandom());
            addr   = 3'($urandom());
            we     = ($urandom() % 6) == 0;
            wdata  = $urandom();
            mcmd   = ($urandom() % 12) == 0;
            ucmd   = ($urandom() % 5) == 0;
            csrc   = SW'($urandom());
            caff   = NC'($urandom());
            if (($urandom() % 200) == 0) begin
                xen = $urandom(); xs = SW'($urandom()); xe = SW'($urandom());
            end
            step();
        end
        idle_inputs(); step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule